// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests for a small microcontroller core and turns them into one vectored acknowledge at a time. It has six serviced sources. Two are external pins with a programmable edge, two are timer overflow pulses, and two are shared groups. One group combines two peripheral event lines and the other combines four. Every source keeps a request flag that is set by its event, whether or not the source is enabled. A per-source enable and one global enable decide which flags may be serviced.

Pending requests are evaluated only on a machine-cycle strobe (`tick`). On a strobe where the global enable is set and the stack is not full, the highest-priority enabled pending source is accepted. In the next cycle the block raises a one-clock acknowledge together with its vector. Acceptance clears the source flag and the global enable. Software can set the global enable again to allow nesting. A group's flag is cleared on service, but the member flags that raised it stay set until software clears them. Configuration goes through a small write-only register port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `ack` is low, the global enable, all enables, all flags and the edge modes are clear, and a strobe produces no acknowledge.
- R2: A source is accepted only when its flag, its enable (address 1, bit i) and the global enable (address 0, bit 0) are all set. With the global enable clear, no source is accepted.
- R3: An event sets its source flag even while the source or the global enable is disabled. The flag stays pending and is accepted at the first strobe after it becomes serviceable.
- R4: Source index i (0 pin 0, 1 pin 1, 2 timer 0, 3 timer 1, 4 group 0, 5 group 1) has vector 0x04+4*i. When several are pending, the lowest index wins.
- R5: Acceptance is evaluated only in a cycle with `tick` high. `ack` and `ack_vec` appear in the following cycle, and `ack` lasts exactly one clock.
- R6: Acceptance clears the global enable, so a later strobe gives no acknowledge until software sets it again.
- R7: No source is accepted in a strobe cycle with `stack_full` high. The request stays pending and is taken at a strobe after `stack_full` falls.
- R8: Acceptance clears only the accepted source's flag. Lower-priority pending flags are served in order at later strobes.
- R9: A group flag is set when any member flag that is enabled at address 4 (group 0 in bits 1:0, group 1 in bits 5:2) newly becomes active. Service clears the group flag but not the member flags. A repeated event on a member that is still set does not raise the group again until software clears that member (address 5, write 1 to clear). A disabled member never raises its group.
- R10: Each pin has a 2-bit edge mode at address 3 (pin 0 in bits 1:0, pin 1 in bits 3:2): 00 no event, 01 rising, 10 falling, 11 both edges. Pins pass through a synchronizer before edge detection.
- R11: Writing 1 to bit i at address 2 clears source flag i. Writing 0 leaves the flag unchanged.
- R12: When an event and a software clear hit the same flag in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Machine-cycle sample strobe |
| ext_pin | input | 2 | External interrupt pins (asynchronous) |
| tmr_ovf | input | 2 | Timer overflow event pulses |
| grp0_evt | input | G0_N | Group 0 member event pulses |
| grp1_evt | input | G1_N | Group 1 member event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| stack_full | input | 1 | Call stack full; holds off acceptance |
| ack | output | 1 | One-clock acknowledge |
| ack_vec | output | VEC_W | Vector of the accepted source |

## Verification
The bench builds the block with its defaults: two synchronizer stages, vector base 4 with step 4, and groups of two and four members. These values place every vector at the listed addresses and let each edge mode be exercised within a few cycles of a pin change. Because the strobe is driven directly, the tests can hold requests pending across many cycles and then land several events on the same strobe. This exposes the priority order, the one-cycle acknowledge latency and the interaction with `stack_full` and the group member flags.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC = 6;
    localparam int SRC_IW = $clog2(NSRC);

    typedef enum logic [2:0] {
        REG_GIE    = 3'd0,
        REG_SRC_EN = 3'd1,
        REG_SRC_CL = 3'd2,
        REG_EDGE   = 3'd3,
        REG_MEM_EN = 3'd4,
        REG_MEM_CL = 3'd5
    } reg_addr_e;

    localparam int SRC_GRP0 = 4;
    localparam int SRC_GRP1 = 5;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] mode,
    output logic       evt
);
    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic                   prev_q, prev_d;
    logic                   lvl, rise, fall;

    always_comb begin
        if (SYNC_STAGES > 1)
            sync_d = {sync_q[SYNC_STAGES-2:0], pin};
        else
            sync_d = pin;
        lvl    = sync_q[SYNC_STAGES-1];
        prev_d = lvl;
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
        evt    = (mode[0] & rise) | (mode[1] & fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assert_evt_needs_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (mode != 2'b00));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N:0] lower_any;
    assign lower_any[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_slot
            assign lower_any[i+1] = lower_any[i] | req[i];
            assign grant[i]       = req[i] & ~lower_any[i];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (grant[k]) idx = IW'(k);
        end
    end

    assign any = lower_any[N];

    always_comb begin
        assert_grant_onehot_R4: assert ($onehot0(grant));
        assert_grant_in_req_R4: assert ((grant & ~req) == '0);
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int VEC_W       = 8,
    parameter int VEC_BASE    = 4,
    parameter int VEC_STEP    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int G0_N        = 2,
    parameter int G1_N        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       ext_pin,
    input  logic [1:0]       tmr_ovf,
    input  logic [G0_N-1:0]  grp0_evt,
    input  logic [G1_N-1:0]  grp1_evt,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic             stack_full,
    output logic             ack,
    output logic [VEC_W-1:0] ack_vec
);
    localparam int MEM_N = G0_N + G1_N;

    typedef struct packed {
        logic             gie;
        logic [NSRC-1:0]  src_en;
        logic [NSRC-1:0]  src_flag;
        logic [3:0]       edge_sel;
        logic [MEM_N-1:0] mem_en;
        logic [MEM_N-1:0] mem_flag;
        logic             ack;
        logic [VEC_W-1:0] vec;
    } ctl_t;

    ctl_t st_q, st_d;

    logic [1:0]        ext_evt;
    logic [NSRC-1:0]   pend, grant;
    logic [SRC_IW-1:0] win_idx;
    logic              win_any;

    genvar p;
    generate
        for (p = 0; p < 2; p++) begin : g_pin
            irq_edge_det #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (ext_pin[p]),
                .mode (st_q.edge_sel[2*p +: 2]),
                .evt  (ext_evt[p])
            );
        end
    endgenerate

    assign pend = st_q.src_flag & st_q.src_en;

    irq_prio_pick #(.N(NSRC), .IW(SRC_IW)) pick_i (
        .req  (pend),
        .grant(grant),
        .idx  (win_idx),
        .any  (win_any)
    );

    logic             accept;
    logic [NSRC-1:0]  src_clr, src_set;
    logic [MEM_N-1:0] mem_clr, mem_evt, act_q, act_d;
    logic             g0_set, g1_set;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        src_clr  = '0;
        mem_clr  = '0;

        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_GIE:    st_d.gie      = wr_data[0];
                REG_SRC_EN: st_d.src_en   = wr_data[NSRC-1:0];
                REG_SRC_CL: src_clr       = wr_data[NSRC-1:0];
                REG_EDGE:   st_d.edge_sel = wr_data[3:0];
                REG_MEM_EN: st_d.mem_en   = wr_data[MEM_N-1:0];
                REG_MEM_CL: mem_clr       = wr_data[MEM_N-1:0];
                default: ;
            endcase
        end

        mem_evt       = {grp1_evt, grp0_evt};
        st_d.mem_flag = (st_q.mem_flag & ~mem_clr) | mem_evt;
        act_q         = st_q.mem_flag & st_q.mem_en;
        act_d         = st_d.mem_flag & st_d.mem_en;
        g0_set        = |(act_d[G0_N-1:0] & ~act_q[G0_N-1:0]);
        g1_set        = |(act_d[MEM_N-1:G0_N] & ~act_q[MEM_N-1:G0_N]);

        accept = tick & st_q.gie & ~stack_full & win_any;
        if (accept) begin
            src_clr  = src_clr | grant;
            st_d.gie = 1'b0;
            st_d.ack = 1'b1;
            st_d.vec = VEC_W'(VEC_BASE + VEC_STEP * int'(win_idx));
        end

        src_set       = {g1_set, g0_set, tmr_ovf, ext_evt};
        st_d.src_flag = (st_q.src_flag & ~src_clr) | src_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack     = st_q.ack;
    assign ack_vec = st_q.vec;

    assert_single_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_ack_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(tick));
    assert_gie_off_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !st_q.gie);
    assert_stack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(!stack_full));
    assert_needs_gie_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(st_q.gie));
    assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (ack_vec >= VEC_W'(VEC_BASE) &&
                 ack_vec <= VEC_W'(VEC_BASE + VEC_STEP * (NSRC - 1))));
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] ext_pin = 2'b00;
    logic [1:0] tmr_ovf = 2'b00;
    logic [1:0] grp0_evt = '0;
    logic [3:0] grp1_evt = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       stack_full = 1'b0;
    logic       ack;
    logic [7:0] ack_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_vector_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ext_pin(ext_pin),
        .tmr_ovf(tmr_ovf), .grp0_evt(grp0_evt), .grp1_evt(grp1_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stack_full(stack_full), .ack(ack), .ack_vec(ack_vec)
    );

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_tmr(input logic [1:0] m);
        tmr_ovf = m; @(negedge clk); tmr_ovf = '0;
    endtask

    task automatic pulse_grp(input logic [1:0] m0, input logic [3:0] m1);
        grp0_evt = m0; grp1_evt = m1; @(negedge clk);
        grp0_evt = '0; grp1_evt = '0;
    endtask

    // strobe once; ack is registered at the edge inside, sampled at the next negedge
    task automatic strobe_expect(input bit exp_ack, input logic [7:0] exp_vec, input string tag);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        checks++;
        if (ack !== exp_ack || (exp_ack && ack_vec !== exp_vec)) begin
            errors++;
            $display("FAIL %s: ack=%0b vec=%02h expected ack=%0b vec=%02h",
                     tag, ack, ack_vec, exp_ack, exp_vec);
        end
        if (ack) begin
            @(negedge clk);
            checks++;
            if (ack !== 1'b0) begin
                errors++;
                $display("FAIL R5 pulse width: ack=%0b expected 0", ack);
            end
        end
    endtask

    task automatic t_reset;
        checks++;
        if (ack !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: ack=%0b expected 0", ack);
        end
        strobe_expect(0, 8'h00, "R1 strobe after reset");
    endtask

    task automatic t_enable_gating;
        wr(3'd0, 8'h01);
        pulse_tmr(2'b01);
        strobe_expect(0, 8'h00, "R3 disabled source held");
        wr(3'd1, 8'h04);
        strobe_expect(1, 8'h0C, "R3 pending taken once enabled");
        pulse_tmr(2'b01);
        strobe_expect(0, 8'h00, "R2 global enable clear blocks");
        wr(3'd0, 8'h01);
        idle(3);
        checks++;
        if (ack !== 1'b0) begin
            errors++;
            $display("FAIL R5 no tick: ack=%0b expected 0", ack);
        end
        strobe_expect(1, 8'h0C, "R2 all three enables set");
    endtask

    task automatic t_priority;
        wr(3'd1, 8'h3F);
        wr(3'd3, 8'h05);
        ext_pin = 2'b11;
        pulse_tmr(2'b11);
        idle(4);
        wr(3'd0, 8'h01);
        strobe_expect(1, 8'h04, "R4 pin0 first");
        strobe_expect(0, 8'h00, "R6 global enable cleared on accept");
        wr(3'd0, 8'h01);
        strobe_expect(1, 8'h08, "R8 pin1 next");
        wr(3'd0, 8'h01);
        strobe_expect(1, 8'h0C, "R8 timer0 next");
        wr(3'd0, 8'h01);
        strobe_expect(1, 8'h10, "R8 timer1 next");
        wr(3'd0, 8'h01);
        strobe_expect(0, 8'h00, "R8 all flags consumed");
    endtask

    task automatic t_groups;
        wr(3'd4, 8'h3F);
        pulse_grp(2'b01, 4'b1000);
        strobe_expect(1, 8'h14, "R4 group0 vector");
        wr(3'd0, 8'h01);
        strobe_expect(1, 8'h18, "R4 group1 vector");
        wr(3'd0, 8'h01);
        pulse_grp(2'b01, 4'b0000);
        strobe_expect(0, 8'h00, "R9 member still set, no re-raise");
        wr(3'd5, 8'h01);
        pulse_grp(2'b01, 4'b0000);
        strobe_expect(1, 8'h14, "R9 member cleared then re-raised");
        wr(3'd5, 8'h3F);
        wr(3'd4, 8'h3D);
        wr(3'd0, 8'h01);
        pulse_grp(2'b10, 4'b0000);
        strobe_expect(0, 8'h00, "R9 disabled member ignored");
        wr(3'd5, 8'h3F);
        wr(3'd4, 8'h3F);
    endtask

    task automatic t_stack;
        wr(3'd0, 8'h01);
        pulse_tmr(2'b10);
        stack_full = 1'b1;
        strobe_expect(0, 8'h00, "R7 held off while stack full");
        stack_full = 1'b0;
        strobe_expect(1, 8'h10, "R7 taken after stack frees");
    endtask

    task automatic t_edges;
        wr(3'd0, 8'h01);
        wr(3'd3, 8'h02);            // pin0 falling; pins currently high
        ext_pin[0] = 1'b0; idle(4);
        strobe_expect(1, 8'h04, "R10 falling edge");
        wr(3'd0, 8'h01);
        ext_pin[0] = 1'b1; idle(4);
        strobe_expect(0, 8'h00, "R10 rising ignored in falling mode");
        wr(3'd3, 8'h00);
        ext_pin[0] = 1'b0; idle(4);
        ext_pin[0] = 1'b1; idle(4);
        strobe_expect(0, 8'h00, "R10 mode 00 gives no event");
        wr(3'd3, 8'h0C);            // pin1 both edges
        ext_pin[1] = 1'b0; idle(4);
        strobe_expect(1, 8'h08, "R10 both-edge fall");
        wr(3'd0, 8'h01);
        ext_pin[1] = 1'b1; idle(4);
        strobe_expect(1, 8'h08, "R10 both-edge rise");
    endtask

    task automatic t_sw_clear;
        wr(3'd0, 8'h01);
        pulse_tmr(2'b10);
        wr(3'd2, 8'h08);
        strobe_expect(0, 8'h00, "R11 write-1 clears flag");
        pulse_tmr(2'b01);
        wr(3'd2, 8'h00);
        strobe_expect(1, 8'h0C, "R11 write-0 keeps flag");
        wr(3'd0, 8'h01);
        tmr_ovf = 2'b01; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h04;
        @(negedge clk);
        tmr_ovf = '0; wr_en = 1'b0;
        strobe_expect(1, 8'h0C, "R12 set wins over clear");
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_enable_gating();
        t_priority();
        t_groups();
        t_stack();
        t_edges();
        t_sw_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule